// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block merges the pending-interrupt vectors of three GPIO banks onto 41 request lines that feed an interrupt controller. Bank 0 has 14 pins, bank 1 has 24 pins and bank 2 has 32 pins. Banks 0 and 1 own dedicated lines. Bank 2 has no lines of its own. It takes over the shared lines 0 to 31 one pin at a time, under control of a 32-bit select register. Three further lines carry, per bank, the OR of those pending pins that are not currently routed to a line of their own.

The pending inputs are already-latched levels from the banks. The block only selects, routes and ORs them, and registers the result, so every output lags its inputs by one clock. Software writes the select register through a single write strobe with a data word, and reads it back on a dedicated read bus.

Top module: `gpio_irq_router`

## Requirements
- R1: The output bus has 41 lines. Lines 0 to 37 are per-pin lines. Line 38 is the bank 0 aggregate, line 39 the bank 1 aggregate and line 40 the bank 2 aggregate.
- R2: For line i with i from 0 to 13, select bit i = 0 drives bank 0 pin i onto the line, and select bit i = 1 drives bank 2 pin i onto it.
- R3: For line i with i from 14 to 31, select bit i = 0 drives bank 1 pin i−14 onto the line, and select bit i = 1 drives bank 2 pin i onto it.
- R4: Lines 32 to 37 always carry bank 1 pins 18 to 23, whatever the select register holds.
- R5: Line 38 is the OR of every bank 0 pin i whose select bit i is 1.
- R6: Line 39 is the OR of every bank 1 pin p (p from 0 to 17) whose select bit p+14 is 1. Bank 1 pins 18 to 23 never reach line 39.
- R7: Line 40 is the OR of every bank 2 pin i whose select bit i is 0.
- R8: A clock edge with `wrEn` = 1 loads `wrData` into the select register, and `rdData` shows the new value after that edge. A clock edge with `wrEn` = 0 leaves the register unchanged, whatever `wrData` holds.
- R9: Every output line is registered. It reflects the pending inputs and the select register as they stood at the previous rising clock edge.
- R10: A synchronous reset (`rstN` = 0 at a rising edge) clears the select register and all 41 output lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Select register write strobe |
| wrData | input | 32 | Select register write data |
| rdData | output | 32 | Current select register value |
| bank0Pend | input | 14 | Bank 0 pending bits |
| bank1Pend | input | 24 | Bank 1 pending bits |
| bank2Pend | input | 32 | Bank 2 pending bits |
| irqLines | output | 41 | Registered interrupt request lines |

## Verification
The assertions assume that the pending inputs and the write port are stable, known levels at every rising edge. They also assume that reset is held low from the first edge, so that outputs and select start from zero. The bench drives every input on the falling edge and asserts reset from time zero. It changes the select register only through complete write cycles, so each routing check sees a select value that has already settled, together with pending vectors that were set half a cycle before the sampling edge.

// File: rtl/gpio_irq_route_pkg.sv
package gpio_irq_route_pkg;
  parameter int BANK0_PINS = 14;
  parameter int BANK1_PINS = 24;
  parameter int BANK2_PINS = 32;

  // Derived layout of the output bus
  localparam int SHARED_LINES = BANK2_PINS;
  localparam int DIRECT_LINES = BANK0_PINS + BANK1_PINS;
  localparam int B1_SHARED    = SHARED_LINES - BANK0_PINS;
  localparam int AGG0_LINE    = DIRECT_LINES;
  localparam int AGG1_LINE    = DIRECT_LINES + 1;
  localparam int AGG2_LINE    = DIRECT_LINES + 2;
  localparam int NUM_LINES    = DIRECT_LINES + 3;

  // Control to datapath: current routing selection
  typedef struct packed {
    logic [BANK2_PINS-1:0] sel;
  } routeCtrl_t;
endpackage

// File: rtl/gpio_irq_route_ctrl.sv
module gpio_irq_route_ctrl
  import gpio_irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [BANK2_PINS-1:0] wrData,
  output logic [BANK2_PINS-1:0] rdData,
  output routeCtrl_t            ctrl
);
  logic [BANK2_PINS-1:0] selReg;

  always_ff @(posedge clk) begin
    if (!rstN)     selReg <= '0;
    else if (wrEn) selReg <= wrData;
  end

  assign rdData   = selReg;
  assign ctrl.sel = selReg;

  // R8: a write lands in the register on the next edge
  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    rstN && wrEn |=> rdData == $past(wrData));
  // R8: without a write the register holds
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !wrEn |=> $stable(rdData));
  // R10: reset clears the select register
  a_r10_sel_reset: assert property (@(posedge clk)
    !rstN |=> rdData == '0);
endmodule

// File: rtl/gpio_irq_route_dp.sv
module gpio_irq_route_dp
  import gpio_irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  routeCtrl_t            ctrl,
  input  logic [BANK0_PINS-1:0] bank0Pend,
  input  logic [BANK1_PINS-1:0] bank1Pend,
  input  logic [BANK2_PINS-1:0] bank2Pend,
  output logic [NUM_LINES-1:0]  irqOut
);
  logic [NUM_LINES-1:0] routeNext;
  logic agg0, agg1, agg2;

  // Per-pin lines: shared lines mux bank 2 in, the rest are fixed to bank 1
  for (genvar i = 0; i < DIRECT_LINES; i++) begin : g_line
    if (i < BANK0_PINS) begin : g_b0
      assign routeNext[i] = ctrl.sel[i] ? bank2Pend[i] : bank0Pend[i];
    end else if (i < SHARED_LINES) begin : g_b1s
      assign routeNext[i] = ctrl.sel[i] ? bank2Pend[i] : bank1Pend[i-BANK0_PINS];
    end else begin : g_b1f
      assign routeNext[i] = bank1Pend[i-BANK0_PINS];
    end
  end

  // Aggregates collect the pins that have lost (or never had) a direct line
  always_comb begin
    agg0 = |(bank0Pend & ctrl.sel[BANK0_PINS-1:0]);
    agg1 = |(bank1Pend[B1_SHARED-1:0] & ctrl.sel[SHARED_LINES-1:BANK0_PINS]);
    agg2 = |(bank2Pend & ~ctrl.sel);
  end

  assign routeNext[AGG0_LINE] = agg0;
  assign routeNext[AGG1_LINE] = agg1;
  assign routeNext[AGG2_LINE] = agg2;

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= routeNext;
  end

  // R4: fixed lines follow bank 1 upper pins one cycle later
  a_r4_fixed_lines: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> irqOut[DIRECT_LINES-1:SHARED_LINES] == $past(bank1Pend[BANK1_PINS-1:B1_SHARED]));
  // R5/R6: with nothing taken over, the bank 0 and bank 1 aggregates stay low
  a_r5_r6_no_takeover: assert property (@(posedge clk) disable iff (!rstN)
    rstN && ctrl.sel == '0 |=> !irqOut[AGG0_LINE] && !irqOut[AGG1_LINE]);
  // R7: with nothing selected, line 40 is the OR of all bank 2 pins
  a_r7_all_indirect: assert property (@(posedge clk) disable iff (!rstN)
    rstN && ctrl.sel == '0 |=> irqOut[AGG2_LINE] == $past(|bank2Pend));
  // R2: a selected line 0 carries bank 2 pin 0
  a_r2_line0_bank2: assert property (@(posedge clk) disable iff (!rstN)
    rstN && ctrl.sel[0] |=> irqOut[0] == $past(bank2Pend[0]));
  // R3: an unselected line 14 carries bank 1 pin 0
  a_r3_line14_bank1: assert property (@(posedge clk) disable iff (!rstN)
    rstN && !ctrl.sel[BANK0_PINS] |=> irqOut[BANK0_PINS] == $past(bank1Pend[0]));
  // R10: reset clears every output line
  a_r10_out_reset: assert property (@(posedge clk)
    !rstN |=> irqOut == '0);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [BANK2_PINS-1:0] wrData,
  output logic [BANK2_PINS-1:0] rdData,
  input  logic [BANK0_PINS-1:0] bank0Pend,
  input  logic [BANK1_PINS-1:0] bank1Pend,
  input  logic [BANK2_PINS-1:0] bank2Pend,
  output logic [NUM_LINES-1:0]  irqLines
);
  routeCtrl_t ctrl;

  gpio_irq_route_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .ctrl   (ctrl)
  );

  gpio_irq_route_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .bank0Pend (bank0Pend),
    .bank1Pend (bank1Pend),
    .bank2Pend (bank2Pend),
    .irqOut    (irqLines)
  );
endmodule

// File: tb/tb_gpio_irq_router.sv
module tb_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [13:0] bank0Pend = '0;
  logic [23:0] bank1Pend = '0;
  logic [31:0] bank2Pend = '0;
  logic [40:0] irqLines;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gpio_irq_router dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .bank0Pend(bank0Pend), .bank1Pend(bank1Pend), .bank2Pend(bank2Pend),
    .irqLines(irqLines)
  );

  typedef struct packed {
    logic [31:0] sel;
    logic [13:0] b0;
    logic [23:0] b1;
    logic [31:0] b2;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 14'h3FFF, 24'hFFFFFF, 32'h0000_0000},
    '{32'h0000_0000, 14'h0000, 24'h000000, 32'hFFFF_FFFF},
    '{32'hFFFF_FFFF, 14'h3FFF, 24'hFFFFFF, 32'h0000_0000},
    '{32'hFFFF_FFFF, 14'h0000, 24'h000000, 32'hFFFF_FFFF},
    '{32'h0000_AAAA, 14'h1555, 24'h123456, 32'h5555_AAAA},
    '{32'h0003_C000, 14'h0000, 24'h00000F, 32'h0000_0000},
    '{32'h0000_0000, 14'h0000, 24'hFC0000, 32'h0000_0000},
    '{32'h8000_0001, 14'h0001, 24'h020000, 32'h7FFF_FFFE}
  };

  // Expected line vector from the requirements
  function automatic logic [40:0] expLines(input logic [31:0] s, input logic [13:0] b0,
                                           input logic [23:0] b1, input logic [31:0] b2);
    logic [40:0] e;
    e = '0;
    for (int i = 0; i < 14; i++) e[i] = s[i] ? b2[i] : b0[i];        // R2
    for (int i = 14; i < 32; i++) e[i] = s[i] ? b2[i] : b1[i-14];    // R3
    for (int i = 32; i < 38; i++) e[i] = b1[i-14];                   // R4
    for (int i = 0; i < 14; i++) if (s[i] && b0[i]) e[38] = 1'b1;    // R5
    for (int p = 0; p < 18; p++) if (s[p+14] && b1[p]) e[39] = 1'b1; // R6
    for (int i = 0; i < 32; i++) if (!s[i] && b2[i]) e[40] = 1'b1;   // R7
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeSel(input logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkAll(input string tag, input logic [40:0] e);
    check({tag, " R2 lines0-13"}, 64'(irqLines[13:0]), 64'(e[13:0]));
    check({tag, " R3 lines14-31"}, 64'(irqLines[31:14]), 64'(e[31:14]));
    check({tag, " R4 lines32-37"}, 64'(irqLines[37:32]), 64'(e[37:32]));
    check({tag, " R5 line38"}, 64'(irqLines[38]), 64'(e[38]));
    check({tag, " R6 line39"}, 64'(irqLines[39]), 64'(e[39]));
    check({tag, " R7 line40"}, 64'(irqLines[40]), 64'(e[40]));
    check({tag, " R1 full bus"}, 64'(irqLines), 64'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [40:0] e;
    // R10: reset state, with inputs active during reset
    bank0Pend = '1; bank1Pend = '1; bank2Pend = '1;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", 64'(irqLines), 64'h0);
    check("R10 reset select", 64'(rdData), 64'h0);
    rstN = 1'b1;
    bank0Pend = '0; bank1Pend = '0; bank2Pend = '0;
    @(negedge clk);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      writeSel(VECS[v].sel);
      check("R8 readback", 64'(rdData), 64'(VECS[v].sel));
      bank0Pend = VECS[v].b0; bank1Pend = VECS[v].b1; bank2Pend = VECS[v].b2;
      @(negedge clk);
      checkAll($sformatf("vec%0d", v), expLines(VECS[v].sel, VECS[v].b0, VECS[v].b1, VECS[v].b2));
    end

    // R9: one cycle of latency on a pending change
    writeSel(32'h0);
    bank0Pend = 14'h0001; bank1Pend = '0; bank2Pend = '0;
    @(negedge clk);
    check("R9 settled", 64'(irqLines[0]), 64'h1);
    bank0Pend = 14'h0000;
    #1;
    check("R9 old value held before edge", 64'(irqLines[0]), 64'h1);
    @(negedge clk);
    check("R9 new value after edge", 64'(irqLines[0]), 64'h0);

    // R8: wrData changes with wrEn low have no effect on select or routing
    writeSel(32'h0000_0001);
    @(negedge clk);
    wrData = 32'hFFFF_FFFE;
    bank0Pend = 14'h0001; bank2Pend = 32'h0000_0000;
    @(negedge clk);
    @(negedge clk);
    check("R8 no write holds select", 64'(rdData), 64'h1);
    e = expLines(32'h1, 14'h0001, 24'h0, 32'h0);
    checkAll("R8 idle", e);

    // R4: fixed lines unaffected by select extremes
    bank1Pend = 24'h5A0000;
    writeSel(32'hFFFF_FFFF);
    check("R4 fixed with sel ones", 64'(irqLines[37:32]), 64'h16);
    writeSel(32'h0);
    check("R4 fixed with sel zeros", 64'(irqLines[37:32]), 64'h16);

    // R10: mid-run reset clears lines and select
    bank2Pend = 32'hFFFF_FFFF;
    writeSel(32'h0000_F0F0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 mid-run outputs", 64'(irqLines), 64'h0);
    check("R10 mid-run select", 64'(rdData), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after reset sel zero", 64'(irqLines[40]), 64'h1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule